// File: doc/BRIEF.md
# Pipelined Delay-Line Tap Counter

This block turns the parallel snapshot of a time-to-digital converter's delay line into a binary number of elapsed taps. A new tap vector may arrive with its valid strobe on every clock. Each vector is first corrected for the polarity flips that an inverting delay chain leaves on alternate taps. Its asserted taps are then counted, and the count comes out a fixed seven clocks later, together with a matching valid flag.

The block counts ones rather than searching for the first zero. An out-of-order bit near the edge, a bubble, therefore moves the result by at most the number of misplaced bits, not by a large jump. The counting runs as a registered tree. A first stage reduces six-tap groups to 3-bit counts through small lookup logic. Adder levels follow, then padding registers that hold the total depth at seven for any tap count. The default build has 180 taps and an 8-bit result. Smaller builds, such as 31 taps with a 5-bit result or 15 taps with a 4-bit result, use the same module with other parameters.

Top module: `tdc_therm_encoder`

## Requirements
- R1: For each accepted sample, `result` equals the number of ones in the polarity-corrected tap vector (for example 3 ones gives 00000011, 5 ones gives 00000101).
- R2: `out_valid` is high exactly when `in_valid` was high seven clocks earlier; a sample captured at one rising edge appears on `result` right after the seventh rising edge counted from that capture.
- R3: Samples offered on consecutive clocks are all accepted, and each produces its own independent result on consecutive clocks.
- R4: Every tap whose bit is set in `INV_MASK` is complemented before counting. By default the mask sets every odd tap index (1, 3, 5, ...), so an all-zero raw input reads as 90 ones in the 180-tap build.
- R5: The result depends only on how many corrected taps are one, not on where they sit. A bubble that swaps a one and a zero near the edge of a thermometer code leaves the result unchanged, and a stray extra bit changes it by exactly one.
- R6: An all-zero corrected vector gives 0 and an all-one corrected vector gives N_TAPS (180 by default); no result ever exceeds N_TAPS.
- R7: A synchronous active-high reset clears every pipeline register. In the clock after reset, `out_valid` is 0 and `result` is 0, and no valid output appears for samples offered while reset was high.
- R8: The result width is ceil(log2(N_TAPS+1)), and builds with other tap counts (31 taps with a 5-bit result, no inversion) keep the seven-clock latency and the ones count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The tap vector on `taps` is a sample |
| taps | input | N_TAPS | Raw sampled delay-line taps |
| out_valid | output | 1 | `result` holds a sample's count |
| result | output | OUT_W | Number of elapsed taps |

## Verification
Polarity correction and bubble tolerance act on the same bit in the same sample when a bubble falls on an odd, inverted tap. The bench builds such codes by placing the bubble at an odd index in the corrected vector, then XORing with the bench's own alternating mask before driving the raw taps. It judges the result against its own count of the corrected vector. A second overlap is a new sample entering while an earlier one leaves the pipeline. Long back-to-back streams and gapped streams check that every result lands on its own clock with its own value.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

    // Taps reduced by one first-stage lookup
    localparam int GROUP_BITS = 6;
    localparam int GROUP_CW   = 3;
    // Total register stages from input to result
    localparam int PIPE_DEPTH = 7;
    // Widest tap vector the default mask covers
    localparam int MAX_TAPS   = 256;

    // Odd tap indices set: an inverting chain flips those positions
    localparam logic [MAX_TAPS-1:0] ALT_MASK = {(MAX_TAPS/2){2'b10}};

    typedef logic [GROUP_CW-1:0] group_cnt_t;

    // Ones count of a six-tap group
    function automatic group_cnt_t count_group(input logic [GROUP_BITS-1:0] g);
        group_cnt_t s;
        s = '0;
        for (int i = 0; i < GROUP_BITS; i++) begin
            s = s + group_cnt_t'(g[i]);
        end
        return s;
    endfunction

endpackage

// File: rtl/tdc_group_stage.sv
module tdc_group_stage #(
    parameter int N_TAPS = 180,
    parameter logic [N_TAPS-1:0] INV_MASK = '0,
    parameter int NGROUP = (N_TAPS + tdc_enc_pkg::GROUP_BITS - 1) / tdc_enc_pkg::GROUP_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic [N_TAPS-1:0] taps,
    output tdc_enc_pkg::group_cnt_t [NGROUP-1:0] cnt
);
    import tdc_enc_pkg::*;

    localparam int PADDED = NGROUP * GROUP_BITS;

    logic [N_TAPS-1:0] fixed;
    logic [PADDED-1:0] padded;

    assign fixed  = taps ^ INV_MASK;
    assign padded = PADDED'(fixed);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            for (int c = 0; c < NGROUP; c++) begin
                cnt[c] <= count_group(padded[c*GROUP_BITS +: GROUP_BITS]);
            end
        end
    end

    // R6: a corrected all-zero snapshot leaves every group count at zero
    assert_zero_groups_R6: assert property (@(posedge clk) disable iff (rst)
        ((taps ^ INV_MASK) == '0) |=> (cnt == '0));

endmodule

// File: rtl/tdc_sum_tree.sv
module tdc_sum_tree #(
    parameter int NGROUP = 30,
    parameter int OUT_W  = 8,
    parameter int LVLS   = (NGROUP > 1) ? $clog2(NGROUP) : 0
) (
    input  logic clk,
    input  logic rst,
    input  tdc_enc_pkg::group_cnt_t [NGROUP-1:0] cnt,
    output logic [OUT_W-1:0] root
);
    if (LVLS == 0) begin : g_flat
        assign root = OUT_W'(cnt[0]);
    end else begin : g_tree
        localparam int LEAF0 = 2 ** LVLS;

        logic [OUT_W-1:0] full   [2:2*LEAF0-1];
        logic [OUT_W-1:0] node_q [1:LEAF0-1];

        for (genvar j = 0; j < LEAF0; j++) begin : g_leaf
            if (j < NGROUP) begin : g_used
                assign full[LEAF0+j] = OUT_W'(cnt[j]);
            end else begin : g_pad
                assign full[LEAF0+j] = '0;
            end
        end

        for (genvar i = 2; i < LEAF0; i++) begin : g_inner
            assign full[i] = node_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 1; i < LEAF0; i++) node_q[i] <= '0;
            end else begin
                for (int i = 1; i < LEAF0; i++) node_q[i] <= full[2*i] + full[2*i+1];
            end
        end

        assign root = node_q[1];
    end

endmodule

// File: rtl/tdc_delay_line.sv
module tdc_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (DEPTH == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] stage [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
            end else begin
                stage[0] <= d;
                for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
            end
        end
        assign q = stage[DEPTH-1];
    end

endmodule

// File: rtl/tdc_therm_encoder.sv
module tdc_therm_encoder #(
    parameter int N_TAPS = 180,
    parameter logic [N_TAPS-1:0] INV_MASK = tdc_enc_pkg::ALT_MASK[N_TAPS-1:0],
    parameter int OUT_W = $clog2(N_TAPS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic [N_TAPS-1:0] taps,
    output logic out_valid,
    output logic [OUT_W-1:0] result
);
    import tdc_enc_pkg::*;

    localparam int NGROUP = (N_TAPS + GROUP_BITS - 1) / GROUP_BITS;
    localparam int LVLS   = (NGROUP > 1) ? $clog2(NGROUP) : 0;
    localparam int PAD    = PIPE_DEPTH - 1 - LVLS;

    group_cnt_t [NGROUP-1:0] grp;
    logic [OUT_W-1:0] total;
    logic [PIPE_DEPTH-1:0] vld_q;

    tdc_group_stage #(.N_TAPS(N_TAPS), .INV_MASK(INV_MASK), .NGROUP(NGROUP)) u_group (
        .clk(clk), .rst(rst), .taps(taps), .cnt(grp)
    );

    tdc_sum_tree #(.NGROUP(NGROUP), .OUT_W(OUT_W), .LVLS(LVLS)) u_tree (
        .clk(clk), .rst(rst), .cnt(grp), .root(total)
    );

    tdc_delay_line #(.W(OUT_W), .DEPTH(PAD)) u_pad (
        .clk(clk), .rst(rst), .d(total), .q(result)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[PIPE_DEPTH-2:0], in_valid};
    end
    assign out_valid = vld_q[PIPE_DEPTH-1];

    // Clocks since reset, so that the latency check never looks back past reset
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd7) |-> (out_valid == $past(in_valid, 7)));

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    assert_result_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result <= OUT_W'(N_TAPS)));

endmodule

// File: tb/test_tdc_therm_encoder.sv
module test_tdc_therm_encoder;
    localparam int N  = 180;
    localparam int W  = 8;
    localparam int NS = 31;
    localparam int WS = 5;

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0;
    logic [N-1:0] taps = '0;
    logic out_valid;
    logic [W-1:0] result;

    logic s_valid = 0;
    logic [NS-1:0] s_taps = '0;
    logic s_out_valid;
    logic [WS-1:0] s_result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int    exp_q[$];
    int    due_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tdc_therm_encoder i_tdc_therm_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .taps(taps),
        .out_valid(out_valid), .result(result)
    );

    tdc_therm_encoder #(.N_TAPS(NS), .INV_MASK('0)) i_tdc_therm_encoder_small (
        .clk(clk), .rst(rst), .in_valid(s_valid), .taps(s_taps),
        .out_valid(s_out_valid), .result(s_result)
    );

    function automatic logic [N-1:0] odd_mask();
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (i % 2 == 1);
        return m;
    endfunction

    function automatic int ones(logic [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) s += int'(v[i]);
        return s;
    endfunction

    function automatic logic [N-1:0] therm(int k);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < k);
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Drive one sample (given as the corrected vector) on the next falling edge
    task automatic send(logic [N-1:0] corr, string tag);
        @(negedge clk);
        in_valid = 1;
        taps = corr ^ odd_mask();
        exp_q.push_back(ones(corr));
        due_q.push_back(cyc + 7);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
            taps = '0;
        end
    endtask

    task automatic drain();
        idle(1);
        while (exp_q.size() != 0) @(negedge clk);
        idle(2);
    endtask

    // Monitor: every valid output must match the oldest queued sample, on its due cycle (R2)
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    check(due_q[0] == cyc, "R2 latency", cyc, due_q[0]);
                    check(int'(result) == exp_q[0], tag_q[0], int'(result), exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (exp_q.size() != 0 && due_q[0] <= cyc) begin
                check(0, "R2 missing out_valid", 0, 1);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic t_reset();
        @(negedge clk);
        rst = 1;
        in_valid = 1;
        taps = '1;
        repeat (3) @(negedge clk);
        rst = 0;
        in_valid = 0;
        taps = '0;
        @(negedge clk);
        check(out_valid == 0, "R7 out_valid after reset", int'(out_valid), 0);
        check(result == '0, "R7 result after reset", int'(result), 0);
        idle(8);
    endtask

    task automatic t_extremes();
        send('0, "R6 all-zero");
        send('1, "R6 all-one gives 180");
        drain();
    endtask

    task automatic t_polarity();
        logic [N-1:0] raw0;
        send(odd_mask(), "R4 raw zero reads 90");
        send(180'b1, "R4 even tap 0 uncorrected");
        send(180'b10, "R4 odd tap 1 flipped");
        drain();
        // raw all-one input: only the even taps count
        raw0 = '1 ^ odd_mask();
        send(raw0, "R4 raw all-one reads 90");
        drain();
    endtask

    task automatic t_thermo();
        int ks[8] = '{0, 1, 3, 4, 5, 90, 179, 180};
        foreach (ks[i]) send(therm(ks[i]), "R1 thermometer code");
        drain();
    endtask

    task automatic t_bubbles();
        logic [N-1:0] v;
        v = therm(60); v[59] = 0; v[60] = 1;
        send(v, "R5 one bubble");
        v = therm(61); v[60] = 0; v[61] = 1; v[58] = 0; v[62] = 1;
        send(v, "R5 two bubbles");
        v = therm(75); v[74] = 0; v[75] = 1; v[72] = 0; v[77] = 1; v[70] = 0; v[79] = 1;
        send(v, "R5 three bubbles");
        v = therm(40); v[41] = 1;
        send(v, "R5 stray bit adds one");
        v = therm(100); v[99] = 0; v[101] = 1;
        send(v, "R5 bubble on inverted odd tap");
        drain();
    endtask

    task automatic t_random();
        logic [N-1:0] v;
        for (int n = 0; n < 50; n++) begin
            for (int i = 0; i < N; i++) v[i] = 1'($urandom_range(0, 1));
            send(v, "R3 back-to-back random");
        end
        drain();
    endtask

    task automatic t_gaps();
        for (int n = 0; n < 10; n++) begin
            send(therm(n * 17), "R2 gapped stream");
            idle(1 + (n % 3));
        end
        drain();
    endtask

    task automatic t_small();
        logic [NS-1:0] vs[3] = '{'1, 31'h0001_FFFF, 31'h5555_0000};
        int es[3] = '{31, 17, 8};
        foreach (vs[i]) begin
            @(negedge clk);
            s_valid = 1;
            s_taps = vs[i];
            @(negedge clk);
            s_valid = 0;
            s_taps = '0;
            repeat (5) @(negedge clk);
            check(s_out_valid == 0, "R8 small not early", int'(s_out_valid), 0);
            @(negedge clk);
            check(s_out_valid == 1, "R8 small latency", int'(s_out_valid), 1);
            check(int'(s_result) == es[i], "R8 small count", int'(s_result), es[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(2);
        t_reset();
        t_extremes();
        t_polarity();
        t_thermo();
        t_bubbles();
        t_random();
        t_gaps();
        t_small();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule